// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the three interrupt flags of a free-running timer: input capture, output compare and counter overflow. It also holds the enable bit that goes with each flag. One-cycle event pulses from the capture edge detector, the compare matcher and the overflow detector set the flags. The flags are returned on a status vector. A single registered interrupt request goes to the CPU whenever any flag is set together with its enable. The CPU's global interrupt mask is applied outside this block.

Software clears a flag with a two-step handshake. First it reads the status register while the flag is set, which arms that flag. Then it accesses the data register that belongs to the flag: the capture low byte, the compare low byte or the counter low byte. Each flag is a three-state machine:

- `FLG_IDLE`: the flag is clear.
- `FLG_PEND`: the flag is set but not armed.
- `FLG_ARMED`: the flag is set and armed.

The transitions are:

- `IDLE->PEND` on an event.
- `PEND->ARMED` on a status read.
- `ARMED->IDLE` on the qualifying access.
- `ARMED->PEND` when an event coincides with that access.
- `ARMED->PEND` on reset, for the flag that reset retains.

Reset clears the compare and overflow flags and all enables. The capture flag keeps its value through reset.

Top module: `tmr_irq_flags`

## Requirements
- R1: An event pulse on a flag's event input sets that flag, visible on `flag_o` one clock after the pulse. Index 0 is capture, index 1 is compare and index 2 is overflow.
- R2: A status read made while a flag is set, followed later by an access to its own data register, clears the flag one clock after the access. The data registers are capture low byte for capture, compare low byte for compare and counter low byte for overflow.
- R3: A data-register access with no earlier status read that saw the flag set leaves the flag set. This includes a status read made while the flag was still clear, and a status read in the same cycle as the access.
- R4: If an event pulse arrives in the same cycle as the clearing access, the flag stays set. That access still uses up the arm, so a further access alone does not clear the flag.
- R5: A control write stores `ctl_wdata_i[7]` as the capture enable, bit 6 as the compare enable and bit 5 as the overflow enable. These appear on `irq_en_o` at indices 0, 1 and 2. Reset clears all three enables.
- R6: `irq_o` is 1 exactly when, in the previous cycle, at least one flag was set together with its enable.
- R7: Reset clears the compare and overflow flags and every arm, and leaves the capture flag unchanged.
- R8: A clearing access for one flag does not change the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_evt_i | input | 1 | Capture edge event pulse |
| cmp_evt_i | input | 1 | Compare match event pulse |
| ovf_evt_i | input | 1 | Counter overflow event pulse |
| stat_rd_i | input | 1 | Status register read strobe |
| cap_lo_acc_i | input | 1 | Capture low byte access strobe |
| cmp_lo_acc_i | input | 1 | Compare low byte access strobe |
| cnt_lo_acc_i | input | 1 | Counter low byte access strobe |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | CTL_W | Control register write data |
| flag_o | output | 3 | Flag vector (capture, compare, overflow) |
| irq_en_o | output | 3 | Enable vector, same index order |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit control word with the enable field at its top three bits. These values reach the real bit positions a neighbouring decoder relies on, so a mis-wired enable bit shows up as a wrong flag or interrupt. Because there are three flags, the bench can clear one flag while another stays armed, and can test the coincident event-and-access case. Reset retention of the capture flag is driven with the flag both set and armed.

// File: rtl/tif_pkg.sv
package tif_pkg;

    localparam int unsigned NFLAG   = 3;
    localparam int unsigned IDX_CAP = 0;
    localparam int unsigned IDX_CMP = 1;
    localparam int unsigned IDX_OVF = 2;

    // Flags that keep their value through reset (capture only)
    localparam logic [NFLAG-1:0] KEEP_ON_RESET = 3'b001;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'b00,
        FLG_PEND  = 2'b01,
        FLG_ARMED = 2'b10
    } flg_state_e;

endpackage

// File: rtl/tif_flag_cell.sv
module tif_flag_cell
    import tif_pkg::*;
#(
    parameter bit KEEP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic stat_rd_i,
    input  logic acc_i,
    output logic flag_o
);

    flg_state_e state_q;
    flg_state_e state_d;
    flg_state_e state_rst;

    // State after reset: retained flags only lose their arm
    always_comb begin
        if (KEEP) begin
            state_rst = (state_q == FLG_ARMED) ? FLG_PEND : state_q;
        end else begin
            state_rst = FLG_IDLE;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (evt_i) begin
                    state_d = FLG_PEND;
                end
            end
            FLG_PEND: begin
                if (stat_rd_i) begin
                    state_d = FLG_ARMED;
                end
            end
            FLG_ARMED: begin
                if (acc_i) begin
                    state_d = evt_i ? FLG_PEND : FLG_IDLE;
                end
            end
            default: begin
                state_d = FLG_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= state_rst;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        flag_o = (state_q == FLG_PEND) || (state_q == FLG_ARMED);
    end

endmodule

// File: rtl/tif_enable_reg.sv
module tif_enable_reg #(
    parameter int unsigned CTL_W  = 8,
    parameter int unsigned EN_TOP = 7,
    parameter int unsigned N      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output logic [N-1:0]     en_o
);

    for (genvar i = 0; i < N; i++) begin : g_en
        localparam int unsigned BIT = EN_TOP - i;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[i] <= 1'b0;
            end else if (we_i) begin
                en_o[i] <= wdata_i[BIT];
            end
        end
    end

endmodule

// File: rtl/tif_irq_merge.sv
module tif_irq_merge #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    logic req_d;

    always_comb begin
        req_d = |(flag_i & en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= req_d;
        end
    end

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tif_pkg::*;
#(
    parameter int unsigned CTL_W  = 8,
    parameter int unsigned EN_TOP = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt_i,
    input  logic             cmp_evt_i,
    input  logic             ovf_evt_i,
    input  logic             stat_rd_i,
    input  logic             cap_lo_acc_i,
    input  logic             cmp_lo_acc_i,
    input  logic             cnt_lo_acc_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic [2:0]       flag_o,
    output logic [2:0]       irq_en_o,
    output logic             irq_o
);

    logic [NFLAG-1:0] evt_vec;
    logic [NFLAG-1:0] acc_vec;

    always_comb begin
        evt_vec          = '0;
        acc_vec          = '0;
        evt_vec[IDX_CAP] = cap_evt_i;
        evt_vec[IDX_CMP] = cmp_evt_i;
        evt_vec[IDX_OVF] = ovf_evt_i;
        acc_vec[IDX_CAP] = cap_lo_acc_i;
        acc_vec[IDX_CMP] = cmp_lo_acc_i;
        acc_vec[IDX_OVF] = cnt_lo_acc_i;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        tif_flag_cell #(
            .KEEP (KEEP_ON_RESET[i])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_vec[i]),
            .stat_rd_i (stat_rd_i),
            .acc_i     (acc_vec[i]),
            .flag_o    (flag_o[i])
        );
    end

    tif_enable_reg #(
        .CTL_W  (CTL_W),
        .EN_TOP (EN_TOP),
        .N      (NFLAG)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_we_i),
        .wdata_i (ctl_wdata_i),
        .en_o    (irq_en_o)
    );

    tif_irq_merge #(
        .N (NFLAG)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_o),
        .en_i   (irq_en_o),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/tif_checker.sv
module tif_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] evt,
    input logic [2:0] acc,
    input logic [2:0] flag,
    input logic [2:0] en,
    input logic       irq
);

    for (genvar i = 0; i < 3; i++) begin : g_chk
        // R1: a flag only rises after its event
        p_rise_needs_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(flag[i]) && flag[i]) |-> $past(evt[i]));

        // R4: an event always leaves the flag set
        p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flag[i]);

        // R2: a flag only falls after its own access with no event
        p_fall_needs_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[i]) |-> ($past(acc[i]) && !$past(evt[i])));
    end

    // R5: reset clears the enables
    p_reset_enables_r5: assert property (@(posedge clk)
        !rst_n |=> (en == 3'b000));

    // R7: reset keeps the capture flag
    p_capture_kept_r7: assert property (@(posedge clk)
        (!rst_n && flag[0]) |=> flag[0]);

    // R6: request follows flag-and-enable by one cycle
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag & en)) |=> irq);

    p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag & en)) |=> !irq);

endmodule

bind tmr_irq_flags tif_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({ovf_evt_i, cmp_evt_i, cap_evt_i}),
    .acc   ({cnt_lo_acc_i, cmp_lo_acc_i, cap_lo_acc_i}),
    .flag  (flag_o),
    .en    (irq_en_o),
    .irq   (irq_o)
);

// File: tb/tmr_irq_flags_tb.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] evt = '0;
    logic       rd = 1'b0;
    logic [2:0] acc = '0;
    logic       we = 1'b0;
    logic [7:0] wd = '0;
    logic [2:0] flag_o;
    logic [2:0] irq_en_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tmr_irq_flags u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_evt_i    (evt[0]),
        .cmp_evt_i    (evt[1]),
        .ovf_evt_i    (evt[2]),
        .stat_rd_i    (rd),
        .cap_lo_acc_i (acc[0]),
        .cmp_lo_acc_i (acc[1]),
        .cnt_lo_acc_i (acc[2]),
        .ctl_we_i     (we),
        .ctl_wdata_i  (wd),
        .flag_o       (flag_o),
        .irq_en_o     (irq_en_o),
        .irq_o        (irq_o)
    );

    // {evt, rd, acc, we, wdata, exp_flags, exp_en}
    localparam int NV = 23;
    localparam logic [21:0] VEC [NV] = '{
        {3'b000, 1'b0, 3'b000, 1'b1, 8'hE0, 3'b000, 3'b111},
        {3'b001, 1'b0, 3'b000, 1'b0, 8'h00, 3'b001, 3'b111},
        {3'b000, 1'b0, 3'b001, 1'b0, 8'h00, 3'b001, 3'b111},
        {3'b000, 1'b1, 3'b000, 1'b0, 8'h00, 3'b001, 3'b111},
        {3'b000, 1'b0, 3'b001, 1'b0, 8'h00, 3'b000, 3'b111},
        {3'b110, 1'b0, 3'b000, 1'b0, 8'h00, 3'b110, 3'b111},
        {3'b000, 1'b1, 3'b000, 1'b0, 8'h00, 3'b110, 3'b111},
        {3'b000, 1'b0, 3'b010, 1'b0, 8'h00, 3'b100, 3'b111},
        {3'b100, 1'b0, 3'b100, 1'b0, 8'h00, 3'b100, 3'b111},
        {3'b000, 1'b0, 3'b100, 1'b0, 8'h00, 3'b100, 3'b111},
        {3'b000, 1'b1, 3'b000, 1'b0, 8'h00, 3'b100, 3'b111},
        {3'b000, 1'b0, 3'b100, 1'b0, 8'h00, 3'b000, 3'b111},
        {3'b000, 1'b0, 3'b000, 1'b1, 8'h40, 3'b000, 3'b010},
        {3'b101, 1'b0, 3'b000, 1'b0, 8'h00, 3'b101, 3'b010},
        {3'b000, 1'b0, 3'b000, 1'b0, 8'h00, 3'b101, 3'b010},
        {3'b010, 1'b0, 3'b000, 1'b0, 8'h00, 3'b111, 3'b010},
        {3'b000, 1'b0, 3'b000, 1'b0, 8'h00, 3'b111, 3'b010},
        {3'b000, 1'b1, 3'b010, 1'b0, 8'h00, 3'b111, 3'b010},
        {3'b000, 1'b0, 3'b010, 1'b0, 8'h00, 3'b101, 3'b010},
        {3'b000, 1'b0, 3'b000, 1'b0, 8'h00, 3'b101, 3'b010},
        {3'b000, 1'b1, 3'b000, 1'b0, 8'h00, 3'b101, 3'b010},
        {3'b010, 1'b0, 3'b000, 1'b0, 8'h00, 3'b111, 3'b010},
        {3'b000, 1'b0, 3'b010, 1'b0, 8'h00, 3'b111, 3'b010}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, let one rising edge pass, clear at the next falling edge
    task automatic step(input logic [2:0] e, input logic r, input logic [2:0] a,
                        input logic w, input logic [7:0] d);
        evt = e; rd = r; acc = a; we = w; wd = d;
        @(negedge clk);
        evt = '0; rd = 1'b0; acc = '0; we = 1'b0; wd = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [2:0] pf;
        logic [2:0] pe;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 capture flag is not reset: bring it to a known clear value first
        if (flag_o[0]) begin
            step(3'b000, 1'b1, 3'b000, 1'b0, 8'h00);
            step(3'b000, 1'b0, 3'b001, 1'b0, 8'h00);
        end
        @(negedge clk);
        check("R7 compare/overflow flags after reset", {6'd0, flag_o[2:1]}, 8'h00);
        check("R5 enables after reset", {5'd0, irq_en_o}, 8'h00);
        check("R6 irq after reset", {7'd0, irq_o}, 8'h00);

        pf = 3'b000;
        pe = 3'b000;
        for (int k = 0; k < NV; k++) begin
            logic [21:0] v;
            v = VEC[k];
            step(v[21:19], v[18], v[17:15], v[14], v[13:6]);
            check($sformatf("R1 R2 R3 R4 R8 flags vec %0d", k), {5'd0, flag_o}, {5'd0, v[5:3]});
            check($sformatf("R5 enables vec %0d", k), {5'd0, irq_en_o}, {5'd0, v[2:0]});
            check($sformatf("R6 irq vec %0d", k), {7'd0, irq_o}, {7'd0, |(pf & pe)});
            pf = v[5:3];
            pe = v[2:0];
        end

        // R7: state is flags 111 with capture armed; reset keeps capture only
        rst_n = 1'b0;
        step(3'b000, 1'b0, 3'b000, 1'b0, 8'h00);
        step(3'b000, 1'b0, 3'b000, 1'b0, 8'h00);
        rst_n = 1'b1;
        check("R7 flags after reset with capture set", {5'd0, flag_o}, 8'h01);
        check("R5 enables cleared by reset", {5'd0, irq_en_o}, 8'h00);
        check("R6 irq cleared by reset", {7'd0, irq_o}, 8'h00);
        // R7: the arm was dropped, so the access alone does not clear
        step(3'b000, 1'b0, 3'b001, 1'b0, 8'h00);
        check("R7 arm cleared by reset", {5'd0, flag_o}, 8'h01);
        step(3'b000, 1'b1, 3'b000, 1'b0, 8'h00);
        step(3'b000, 1'b0, 3'b001, 1'b0, 8'h00);
        check("R2 capture cleared after fresh handshake", {5'd0, flag_o}, 8'h00);
        // R5: each enable bit position individually
        step(3'b000, 1'b0, 3'b000, 1'b1, 8'h20);
        check("R5 bit5 enables overflow", {5'd0, irq_en_o}, 8'h04);
        step(3'b000, 1'b0, 3'b000, 1'b1, 8'h9F);
        check("R5 bit7 enables capture only", {5'd0, irq_en_o}, 8'h01);
        step(3'b001, 1'b0, 3'b000, 1'b0, 8'h00);
        step(3'b000, 1'b0, 3'b000, 1'b0, 8'h00);
        check("R6 irq from capture with enable", {7'd0, irq_o}, 8'h01);

        finish_run();
    end

endmodule